// File: doc/BRIEF.md
# Stack Pointer and Push/Pop Sequencer

This block carries out the stack operations of a small 8/16-bit processor core. It holds the 16-bit stack pointer and moves data between the core and a byte-wide data memory. Each push or pop is broken into single-byte accesses, and each access takes one cycle. The status byte always travels with a zero pad byte, so the stack pointer stays even when it starts even. Pointer-only operations complete in one step. These are loading the pointer, copying it out, and adding or subtracting an unsigned byte.

The instruction decoder issues one command at a time with a valid strobe. Each command carries an operation code, a 16-bit immediate, the value of a register pair, the current status byte and a destination-pair code. The sequencer raises busy while the command runs. One cycle after the last step it pulses done, together with the number of steps used and any result for the register file or the status register. The memory has an asynchronous read port: read data belongs to the address presented in the same cycle. Writes take effect at the clock edge.

Top module: `stack_seq`

## Requirements
- R1: Push status (op 0) writes the status byte to SP-1 in step 0, writes 00h to SP-2 in step 1, and leaves SP lowered by 2. It takes 2 steps.
- R2: Push pair (op 2) writes the high byte of the pair to SP-1 in step 0 and the low byte to SP-2 in step 1, and leaves SP lowered by 2. It takes 2 steps.
- R3: Pop status (op 1) reads SP+1 into res_psw and never uses the byte at SP. It pulses psw_we with done and leaves SP raised by 2. It takes 3 steps.
- R4: Pop pair (op 3) reads the low byte from SP in step 0 and the high byte from SP+1 in step 1. It returns the pair on res_rp with rp_we and leaves SP raised by 2. It takes 2 steps.
- R5: Load SP from the 16-bit immediate (op 4) or from the pair input (op 5) takes 1 step.
- R6: Copy SP out (op 6) returns SP on res_rp with rp_we and echoes the destination code cmd_pair on rp_dst. It takes 1 step and leaves SP unchanged.
- R7: Add (op 7) and subtract (op 8) change SP by the unsigned low byte of the immediate and ignore its upper byte. They take 1 step. All SP arithmetic wraps modulo 2^16 with no flag.
- R8: A command is accepted only while busy is low. busy stays high for the command's steps, and cmd_valid during busy is ignored. done is a one-cycle pulse in the cycle after the last step, with busy low, SP updated and cyc_used equal to the step count.
- R9: Operation codes 9 to 15 are ignored: no busy, no done, no memory write and no SP change.
- R10: mem_we is high only during push steps, psw_we only with the done of a status pop, and SP changes only in a done cycle.
- R11: After reset SP equals the SP_RESET parameter, busy, done, mem_we, rp_we and psw_we are low, and mem_addr shows SP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Operation code |
| cmd_imm | input | 16 | Immediate word, or byte in bits 7:0 |
| cmd_rp | input | 16 | Register pair value for push or SP load |
| cmd_psw | input | 8 | Status byte for push |
| cmd_pair | input | 2 | Destination pair code for SP copy |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| cyc_used | output | 2 | Steps taken by the finished command |
| sp | output | 16 | Current stack pointer |
| res_rp | output | 16 | Pair result from pop or SP copy |
| rp_we | output | 1 | res_rp valid, pulses with done |
| rp_dst | output | 2 | Destination pair code of the last command |
| res_psw | output | 8 | Status byte from pop |
| psw_we | output | 1 | res_psw valid, pulses with done |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_we | output | 1 | Write enable |
| mem_rdata | input | 8 | Read data for mem_addr |

## Verification
A wrong step count or a stale step register shows in cyc_used and in the timing of done. It also shows on mem_addr within the same command, as a byte at the wrong offset from SP. A wrong SP update is visible on the sp port at the next done. It also corrupts the address of every later push or pop, so a push-then-pop pair that does not return its data exposes it within four cycles. Address wrap is checked by pushing across address zero and popping back, and by add and subtract that cross the 16-bit boundary.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;
  localparam int OP_W   = 4;
  localparam int STEP_W = 2;

  typedef enum logic [OP_W-1:0] {
    OP_PUSH_PSW = 4'h0,
    OP_POP_PSW  = 4'h1,
    OP_PUSH_RP  = 4'h2,
    OP_POP_RP   = 4'h3,
    OP_LD_IMM   = 4'h4,
    OP_LD_RP    = 4'h5,
    OP_RD_SP    = 4'h6,
    OP_ADD_SP   = 4'h7,
    OP_SUB_SP   = 4'h8
  } stk_op_e;

  // index of the final step of each operation
  function automatic logic [STEP_W-1:0] op_last(input logic [OP_W-1:0] op);
    case (op)
      OP_PUSH_PSW, OP_PUSH_RP, OP_POP_RP: op_last = STEP_W'(1);
      OP_POP_PSW:                         op_last = STEP_W'(2);
      default:                            op_last = '0;
    endcase
  endfunction

  function automatic logic op_known(input logic [OP_W-1:0] op);
    op_known = (op <= OP_SUB_SP);
  endfunction
endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  output logic              busy,
  output logic              accept,
  output logic              finish,
  output logic [OP_W-1:0]   op_q,
  output logic [STEP_W-1:0] step,
  output logic              done,
  output logic [STEP_W-1:0] cyc_used
);
  logic              busy_q, busy_d;
  logic [STEP_W-1:0] step_q, step_d, last_q, last_d;
  logic [OP_W-1:0]   op_d;
  logic              done_q;
  logic [STEP_W-1:0] cyc_q, cyc_d;

  assign accept = cmd_valid & ~busy_q & op_known(cmd_op);
  assign finish = busy_q & (step_q == last_q);

  always_comb begin
    busy_d = busy_q;
    step_d = step_q;
    last_d = last_q;
    op_d   = op_q;
    cyc_d  = cyc_q;
    if (accept) begin
      busy_d = 1'b1;
      step_d = '0;
      last_d = op_last(cmd_op);
      op_d   = cmd_op;
    end else if (finish) begin
      busy_d = 1'b0;
      cyc_d  = last_q + STEP_W'(1);
    end else if (busy_q) begin
      step_d = step_q + STEP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      step_q <= '0;
      last_q <= '0;
      op_q   <= '0;
      cyc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      step_q <= step_d;
      last_q <= last_d;
      op_q   <= op_d;
      cyc_q  <= cyc_d;
      done_q <= finish;
    end
  end

  assign busy     = busy_q;
  assign step     = step_q;
  assign done     = done_q;
  assign cyc_used = cyc_q;
endmodule

// File: rtl/stack_seq_port.sv
module stack_seq_port
  import stack_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic              busy,
  input  logic [OP_W-1:0]   op_q,
  input  logic [STEP_W-1:0] step,
  input  logic [AW-1:0]     sp,
  input  logic [2*DW-1:0]   opnd_q,
  input  logic [DW-1:0]     psw_q,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we
);
  logic first;
  assign first = (step == '0);

  always_comb begin
    mem_addr  = sp;
    mem_wdata = '0;
    mem_we    = 1'b0;
    if (busy) begin
      case (op_q)
        OP_PUSH_PSW: begin
          mem_we    = 1'b1;
          mem_addr  = first ? sp - AW'(1) : sp - AW'(2);
          mem_wdata = first ? psw_q : '0;
        end
        OP_PUSH_RP: begin
          mem_we    = 1'b1;
          mem_addr  = first ? sp - AW'(1) : sp - AW'(2);
          mem_wdata = first ? opnd_q[2*DW-1:DW] : opnd_q[DW-1:0];
        end
        OP_POP_RP:  mem_addr = first ? sp : sp + AW'(1);
        OP_POP_PSW: mem_addr = sp + AW'(1);
        default:    mem_addr = sp;
      endcase
    end
  end
endmodule

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] SP_RESET = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              finish,
  input  logic              busy,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [OP_W-1:0]   op_q,
  input  logic [STEP_W-1:0] step,
  input  logic [2*DW-1:0]   cmd_imm,
  input  logic [2*DW-1:0]   cmd_rp,
  input  logic [DW-1:0]     cmd_psw,
  input  logic [1:0]        cmd_pair,
  input  logic [DW-1:0]     mem_rdata,
  output logic [AW-1:0]     sp,
  output logic [2*DW-1:0]   opnd_q,
  output logic [DW-1:0]     psw_q,
  output logic [2*DW-1:0]   res_rp,
  output logic              rp_we,
  output logic [1:0]        rp_dst,
  output logic [DW-1:0]     res_psw,
  output logic              psw_we
);
  logic [AW-1:0]   sp_q, sp_d;
  logic [2*DW-1:0] opnd_d, res_rp_d;
  logic [DW-1:0]   lo_q, res_psw_d;
  logic            cap_lo, cap_psw, rp_we_d, psw_we_d;
  logic            imm_src;

  assign imm_src = (cmd_op == OP_LD_IMM) | (cmd_op == OP_ADD_SP) | (cmd_op == OP_SUB_SP);
  assign opnd_d  = imm_src ? cmd_imm : cmd_rp;
  assign cap_lo  = busy & (op_q == OP_POP_RP)  & (step == '0);
  assign cap_psw = busy & (op_q == OP_POP_PSW) & (step == '0);

  always_comb begin
    sp_d     = sp_q;
    res_rp_d = res_rp;
    rp_we_d  = 1'b0;
    psw_we_d = 1'b0;
    res_psw_d = cap_psw ? mem_rdata : res_psw;
    if (finish) begin
      case (op_q)
        OP_PUSH_PSW, OP_PUSH_RP: sp_d = sp_q - AW'(2);
        OP_POP_PSW: begin
          sp_d     = sp_q + AW'(2);
          psw_we_d = 1'b1;
        end
        OP_POP_RP: begin
          sp_d     = sp_q + AW'(2);
          res_rp_d = {mem_rdata, lo_q};
          rp_we_d  = 1'b1;
        end
        OP_LD_IMM, OP_LD_RP: sp_d = AW'(opnd_q);
        OP_RD_SP: begin
          res_rp_d = (2*DW)'(sp_q);
          rp_we_d  = 1'b1;
        end
        OP_ADD_SP: sp_d = sp_q + AW'(opnd_q[DW-1:0]);
        OP_SUB_SP: sp_d = sp_q - AW'(opnd_q[DW-1:0]);
        default:   sp_d = sp_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp_q    <= SP_RESET;
      opnd_q  <= '0;
      psw_q   <= '0;
      rp_dst  <= '0;
      lo_q    <= '0;
      res_rp  <= '0;
      res_psw <= '0;
      rp_we   <= 1'b0;
      psw_we  <= 1'b0;
    end else begin
      if (accept) begin
        opnd_q <= opnd_d;
        psw_q  <= cmd_psw;
        rp_dst <= cmd_pair;
      end
      if (cap_lo) lo_q <= mem_rdata;
      if (finish) sp_q <= sp_d;
      res_rp  <= res_rp_d;
      res_psw <= res_psw_d;
      rp_we   <= rp_we_d;
      psw_we  <= psw_we_d;
    end
  end

  assign sp = sp_q;
endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter int            AW       = 16,
  parameter int            DW       = 8,
  parameter logic [AW-1:0] SP_RESET = 16'h00F0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [OP_W-1:0]   cmd_op,
  input  logic [2*DW-1:0]   cmd_imm,
  input  logic [2*DW-1:0]   cmd_rp,
  input  logic [DW-1:0]     cmd_psw,
  input  logic [1:0]        cmd_pair,
  output logic              busy,
  output logic              done,
  output logic [STEP_W-1:0] cyc_used,
  output logic [AW-1:0]     sp,
  output logic [2*DW-1:0]   res_rp,
  output logic              rp_we,
  output logic [1:0]        rp_dst,
  output logic [DW-1:0]     res_psw,
  output logic              psw_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              mem_we,
  input  logic [DW-1:0]     mem_rdata
);
  logic              accept, finish;
  logic [OP_W-1:0]   op_q;
  logic [STEP_W-1:0] step;
  logic [2*DW-1:0]   opnd_q;
  logic [DW-1:0]     psw_q;

  stack_seq_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .accept(accept), .finish(finish), .op_q(op_q),
    .step(step), .done(done), .cyc_used(cyc_used)
  );

  stack_seq_dp #(.AW(AW), .DW(DW), .SP_RESET(SP_RESET)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .finish(finish), .busy(busy),
    .cmd_op(cmd_op), .op_q(op_q), .step(step), .cmd_imm(cmd_imm),
    .cmd_rp(cmd_rp), .cmd_psw(cmd_psw), .cmd_pair(cmd_pair),
    .mem_rdata(mem_rdata), .sp(sp), .opnd_q(opnd_q), .psw_q(psw_q),
    .res_rp(res_rp), .rp_we(rp_we), .rp_dst(rp_dst), .res_psw(res_psw),
    .psw_we(psw_we)
  );

  stack_seq_port #(.AW(AW), .DW(DW)) u_port (
    .busy(busy), .op_q(op_q), .step(step), .sp(sp), .opnd_q(opnd_q),
    .psw_q(psw_q), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we)
  );
endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    cyc_used,
  input logic [AW-1:0] sp,
  input logic          psw_we,
  input logic          rp_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_we
);
  // R8: completion is reported only once the sequence has ended
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10: the pointer moves only in a done cycle
  a_r10_sp_at_done: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sp) |-> done);
  // R10: status strobe belongs to the three-step status pop
  a_r10_psw_we_pop: assert property (@(posedge clk) disable iff (!rst_n)
    psw_we |-> (done && cyc_used == 2'd3));
  // R10: memory writes only inside a running command
  a_r10_we_busy: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  // R1 / R2: the second write of a push lands one byte below the first
  a_r2_write_descend: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - AW'(1)));
  // R4 / R6: pair results come with done
  a_r6_rp_we_done: assert property (@(posedge clk) disable iff (!rst_n)
    rp_we |-> done);
endmodule

bind stack_seq stack_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .cyc_used(cyc_used),
  .sp(sp), .psw_we(psw_we), .rp_we(rp_we), .mem_addr(mem_addr), .mem_we(mem_we)
);

// File: tb/tb_stack_seq.sv
`timescale 1ns/1ps
module tb_stack_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = '0;
  logic [15:0] cmd_imm = '0, cmd_rp = '0;
  logic [7:0]  cmd_psw = '0;
  logic [1:0]  cmd_pair = '0;
  logic        busy, done, rp_we, psw_we, mem_we;
  logic [1:0]  cyc_used, rp_dst;
  logic [15:0] sp, res_rp, mem_addr;
  logic [7:0]  res_psw, mem_wdata, mem_rdata;

  logic [7:0] mem [0:255];
  int n_tests = 0, n_fail = 0, wr_cnt = 0;

  always #2.5 clk = ~clk;

  stack_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_imm(cmd_imm), .cmd_rp(cmd_rp), .cmd_psw(cmd_psw), .cmd_pair(cmd_pair),
    .busy(busy), .done(done), .cyc_used(cyc_used), .sp(sp), .res_rp(res_rp),
    .rp_we(rp_we), .rp_dst(rp_dst), .res_psw(res_psw), .psw_we(psw_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
    .mem_rdata(mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[7:0]];
  always @(posedge clk) if (mem_we) begin
    mem[mem_addr[7:0]] <= mem_wdata;
    wr_cnt <= wr_cnt + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [3:0] op, input logic [15:0] imm, input logic [15:0] rp,
                     input logic [7:0] psw, input logic [1:0] pair, output int n);
    @(negedge clk);
    cmd_op = op; cmd_imm = imm; cmd_rp = rp; cmd_psw = psw; cmd_pair = pair;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 0;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset;
    chk(sp == 16'h00F0, "R11 sp", sp, 16'h00F0);
    chk(!busy && !done && !mem_we && !rp_we && !psw_we, "R11 idle", {busy, done, mem_we}, 0);
    chk(mem_addr == sp, "R11 addr", mem_addr, sp);
  endtask

  task automatic t_push_psw;
    int n;
    mem[8'hEF] = 8'h33; mem[8'hEE] = 8'h33;
    run(4'h0, 16'h0, 16'h0, 8'hA5, 2'd0, n);
    chk(n == 2 && cyc_used == 2'd2, "R1 steps", n, 2);
    chk(sp == 16'h00EE, "R1 sp", sp, 16'h00EE);
    chk(mem[8'hEF] == 8'hA5, "R1 status byte", mem[8'hEF], 8'hA5);
    chk(mem[8'hEE] == 8'h00, "R1 pad byte", mem[8'hEE], 8'h00);
    chk(!psw_we && !rp_we, "R10 push strobes", {psw_we, rp_we}, 0);
  endtask

  task automatic t_push_pop_rp;
    int n;
    run(4'h2, 16'h0, 16'h1234, 8'h0, 2'd0, n);
    chk(n == 2, "R2 steps", n, 2);
    chk(mem[8'hED] == 8'h12 && mem[8'hEC] == 8'h34, "R2 bytes", {mem[8'hED], mem[8'hEC]}, 16'h1234);
    chk(sp == 16'h00EC, "R2 sp", sp, 16'h00EC);
    run(4'h3, 16'h0, 16'h0, 8'h0, 2'd0, n);
    chk(n == 2 && cyc_used == 2'd2, "R4 steps", n, 2);
    chk(rp_we && res_rp == 16'h1234, "R4 data", res_rp, 16'h1234);
    chk(sp == 16'h00EE, "R4 sp", sp, 16'h00EE);
  endtask

  task automatic t_pop_psw;
    int n;
    mem[8'hEE] = 8'h77;
    run(4'h1, 16'h0, 16'h0, 8'h0, 2'd0, n);
    chk(n == 3 && cyc_used == 2'd3, "R3 steps", n, 3);
    chk(psw_we && res_psw == 8'hA5, "R3 status", res_psw, 8'hA5);
    chk(sp == 16'h00F0, "R3 sp", sp, 16'h00F0);
  endtask

  task automatic t_load_copy;
    int n;
    int w0;
    w0 = wr_cnt;
    run(4'h4, 16'h0040, 16'hDEAD, 8'h0, 2'd0, n);
    chk(n == 1 && sp == 16'h0040, "R5 load imm", sp, 16'h0040);
    run(4'h5, 16'hDEAD, 16'h0080, 8'h0, 2'd0, n);
    chk(n == 1 && sp == 16'h0080, "R5 load pair", sp, 16'h0080);
    run(4'h6, 16'h0, 16'h0, 8'h0, 2'd2, n);
    chk(n == 1 && rp_we && res_rp == 16'h0080, "R6 copy", res_rp, 16'h0080);
    chk(rp_dst == 2'd2 && sp == 16'h0080, "R6 dst", rp_dst, 2);
    chk(wr_cnt == w0 && !psw_we, "R10 no writes", wr_cnt - w0, 0);
  endtask

  task automatic t_add_sub;
    int n;
    run(4'h7, 16'hAB05, 16'h0, 8'h0, 2'd0, n);
    chk(n == 1 && sp == 16'h0085, "R7 add low byte", sp, 16'h0085);
    run(4'h8, 16'h0080, 16'h0, 8'h0, 2'd0, n);
    chk(sp == 16'h0005, "R7 sub", sp, 16'h0005);
    run(4'h8, 16'h0010, 16'h0, 8'h0, 2'd0, n);
    chk(sp == 16'hFFF5, "R7 sub wrap", sp, 16'hFFF5);
    run(4'h7, 16'h00FF, 16'h0, 8'h0, 2'd0, n);
    chk(sp == 16'h00F4, "R7 add wrap", sp, 16'h00F4);
  endtask

  task automatic t_wrap_stack;
    int n;
    run(4'h4, 16'h0001, 16'h0, 8'h0, 2'd0, n);
    run(4'h2, 16'h0, 16'hBEEF, 8'h0, 2'd0, n);
    chk(sp == 16'hFFFF, "R2 push wrap sp", sp, 16'hFFFF);
    chk(mem[8'h00] == 8'hBE && mem[8'hFF] == 8'hEF, "R2 push wrap bytes", {mem[8'h00], mem[8'hFF]}, 16'hBEEF);
    run(4'h3, 16'h0, 16'h0, 8'h0, 2'd0, n);
    chk(res_rp == 16'hBEEF && sp == 16'h0001, "R4 pop wrap", res_rp, 16'hBEEF);
  endtask

  task automatic t_busy_ignore;
    int n;
    run(4'h4, 16'h00C0, 16'h0, 8'h0, 2'd0, n);
    @(negedge clk);
    cmd_op = 4'h1; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_op = 4'h7; cmd_imm = 16'h0010;
    @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 2;
    while (!done && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(n == 3, "R8 busy length", n, 3);
    chk(sp == 16'h00C2, "R8 ignored while busy", sp, 16'h00C2);
    repeat (3) @(negedge clk);
    chk(!busy && !done && sp == 16'h00C2, "R8 stays idle", sp, 16'h00C2);
  endtask

  task automatic t_undef;
    int w0;
    int seen;
    w0 = wr_cnt;
    seen = 0;
    @(negedge clk);
    cmd_op = 4'hB; cmd_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (busy || done) seen++;
      if (i == 1) cmd_op = 4'hF;
    end
    cmd_valid = 1'b0;
    @(negedge clk);
    chk(seen == 0 && !done, "R9 no activity", seen, 0);
    chk(sp == 16'h00C2 && wr_cnt == w0, "R9 sp kept", sp, 16'h00C2);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_push_psw();
    t_push_pop_rp();
    t_pop_psw();
    t_load_copy();
    t_add_sub();
    t_wrap_stack();
    t_busy_ignore();
    t_undef();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule